// File: doc/BRIEF.md
# Multi-Operand Decimal Adder with Deferred Correction

This block adds M unsigned decimal numbers, each held as N packed 4-bit BCD digits, and returns their total as a BCD word. The word is wide enough that the total never overflows. Every digit column reduces its operand digits in a tree of 4-bit binary carry-save compressors. The tree makes no decimal adjustment while it reduces. Each compressor's weight-16 carry bit leaves the column and enters the matching compressor of the next column up.

When the tree has finished, the column holds a 5-bit binary remainder and a count of the carries it sent upward. One small correction stage turns this pair into a valid decimal digit and a multi-bit count of decimal carries still owed to the next column. A final word-level stage merges the digits with the owed carries. It first splits each merged column into a tens part and a units part, so that the last decimal carry-lookahead only has to deal with single-bit carries.

The sum is computed combinationally and then registered. A result appears one clock after an input strobe and is held until the next strobe. The supported parameter range is M from 3 to 20 and N of 1 or more. The result carries N plus ceil(log10(M)) digits, with a minimum of one extra digit.

Top module: `bcd_multi_adder`

## Requirements
- R1: When `in_valid` is high at a rising edge, `sum_out` after that edge equals the decimal sum of the M operands.
- R2: `sum_out` has N+X digits, where X = ceil(log10(M)) with a minimum of 1. When every operand digit is 9, the full total (M × (10^N − 1)) appears without loss.
- R3: Whenever `out_valid` is high, every 4-bit digit of `sum_out` lies in 0..9.
- R4: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R5: A synchronous active-high `rst` clears `out_valid` to 0 and `sum_out` to all zeros at the next rising edge.
- R6: While `in_valid` is low, changes on `operands` have no effect: `sum_out` keeps its last value.
- R7: Operand k occupies bits [k·4N +: 4N] of `operands`. Within an operand, digit d (d = 0 is least significant) sits at bits [4d +: 4]. The same digit order applies to `sum_out`.
- R8: All-zero operands give an all-zero sum.
- R9: A column whose binary total covers several decades is corrected exactly. With M = 5 and units digits 9, 8, 7, 6 and 5 (all other digits 0), the result is 35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: capture the sum of the present operands |
| operands | input | M*N*4 | Packed BCD operands, operand 0 in the lowest bits |
| out_valid | output | 1 | High for one cycle with each new result |
| sum_out | output | (N+X)*4 | Registered BCD total |

## Verification
A bad forwarded carry, or a bad correction in any column, shows up in the very next result word. It appears as a wrong digit in that column or the one above it, and often as a digit of 10 to 15, which the per-digit range check catches in the same cycle. A carry that leaks out of the top column means the result word was sized too narrow. An internal check flags it in the input cycle, before the register captures it. Stale or spurious captures show as a change of the held sum while the strobe is low, one cycle after the operands move.

// File: rtl/bcd_madd_pkg.sv
package bcd_madd_pkg;

  // Extra result digits needed so that m operands of all nines never overflow.
  function automatic int extra_digits(input int m);
    int d;
    int lim;
    d = 0;
    lim = 1;
    for (int i = 0; i < 6; i++) begin
      if (lim < m) begin
        lim = lim * 10;
        d = d + 1;
      end
    end
    return (d < 1) ? 1 : d;
  endfunction

  // Bits needed to count up to m.
  function automatic int count_width(input int m);
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/bcd_csa_node.sv
// One 4-bit 3:2 compressor. cry[k] carries weight 2^(k+1); cry[3] is the
// weight-16 bit that leaves the digit column.
module bcd_csa_node (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic [3:0] c,
  output logic [3:0] sum,
  output logic [3:0] cry
);
  assign sum = a ^ b ^ c;
  assign cry = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/bcd_column.sv
// Binary carry-save reduction of one digit column. Compressors take rows
// in first-in first-out order, so the resulting tree has logarithmic depth.
module bcd_column #(
  parameter int M = 5
) (
  input  logic [M-1:0][3:0] op_dig,
  input  logic [M-3:0]      cin,
  output logic [M-3:0]      cfwd,
  output logic [4:0]        z0
);
  localparam int NODES = M - 2;
  localparam int ROWS  = 3 * M - 4;

  logic [3:0] rows [ROWS];

  for (genvar r = 0; r < M; r++) begin : g_in
    assign rows[r] = op_dig[r];
  end

  for (genvar k = 0; k < NODES; k++) begin : g_node
    logic [3:0] s_k;
    logic [3:0] cy_k;
    bcd_csa_node u_node (
      .a  (rows[3*k]),
      .b  (rows[3*k+1]),
      .c  (rows[3*k+2]),
      .sum(s_k),
      .cry(cy_k)
    );
    assign rows[M+2*k]   = s_k;
    assign rows[M+2*k+1] = {cy_k[2:0], cin[k]};
    assign cfwd[k]       = cy_k[3];
  end

  assign z0 = {1'b0, rows[ROWS-2]} + {1'b0, rows[ROWS-1]};
endmodule

// File: rtl/bcd_digit_fix.sv
// Turns the column remainder and its forwarded-carry count into a decimal
// digit and the count of decimal carries still owed upward.
module bcd_digit_fix
  import bcd_madd_pkg::*;
#(
  parameter int M = 5
) (
  input  logic [4:0]                z0,
  input  logic [M-3:0]              cfwd,
  output logic [3:0]                digit,
  output logic [count_width(M)-1:0] cout
);
  localparam int CW = count_width(M);
  localparam int TW = $clog2(16 * M + 32);

  logic [CW-1:0] fwd;
  logic [TW-1:0] tot;
  logic [TW-1:0] tens;
  logic [3:0]    g;

  always_comb begin
    fwd = '0;
    for (int k = 0; k < M - 2; k++) begin
      fwd = fwd + CW'(cfwd[k]);
    end
    tot   = TW'(z0) + (TW'(fwd) << 4);
    tens  = tot / TW'(10);
    g     = 4'(tens[3:0] * 4'd6);
    digit = z0[3:0] + g;
    cout  = CW'(tens - TW'(fwd));
  end
endmodule

// File: rtl/bcd_final_cla.sv
// Merges column digits with owed multi-bit carries. A tens/units split
// leaves at most one carry per digit, which a parallel-prefix lookahead resolves.
module bcd_final_cla
  import bcd_madd_pkg::*;
#(
  parameter int M  = 5,
  parameter int RD = 5
) (
  input  logic [RD-1:0][3:0]                digs,
  input  logic [RD-2:0][count_width(M)-1:0] owed,
  output logic [RD-1:0][3:0]                sum
);
  localparam int WW = $clog2(M + 9);

  logic [WW-1:0] w  [RD];
  logic [1:0]    hi [RD];
  logic [3:0]    lo [RD];
  logic [3:0]    x  [RD];
  logic          gg [RD];
  logic          pp [RD];
  logic [3:0]    y;

  always_comb begin
    for (int j = 0; j < RD; j++) begin
      if (j == 0) w[j] = WW'(digs[j]);
      else        w[j] = WW'(digs[j]) + WW'(owed[j-1]);
      hi[j] = 2'(w[j] / WW'(10));
      lo[j] = 4'(w[j] % WW'(10));
    end
    for (int j = 0; j < RD; j++) begin
      if (j == 0) x[j] = lo[j];
      else        x[j] = lo[j] + {2'b00, hi[j-1]};
      gg[j] = (x[j] >= 4'd10);
      pp[j] = (x[j] == 4'd9);
    end
    for (int lv = 0; (1 << lv) < RD; lv++) begin
      for (int j = RD - 1; j >= (1 << lv); j--) begin
        gg[j] = gg[j] | (pp[j] & gg[j - (1 << lv)]);
        pp[j] = pp[j] & pp[j - (1 << lv)];
      end
    end
    for (int j = 0; j < RD; j++) begin
      if (j == 0) y = x[j];
      else        y = x[j] + {3'b000, gg[j-1]};
      sum[j] = (y >= 4'd10) ? y - 4'd10 : y;
    end
  end
endmodule

// File: rtl/bcd_multi_adder.sv
module bcd_multi_adder
  import bcd_madd_pkg::*;
#(
  parameter int M = 5,
  parameter int N = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  input  logic [M*N*4-1:0]                operands,
  output logic                            out_valid,
  output logic [(N+extra_digits(M))*4-1:0] sum_out
);
  localparam int XD    = extra_digits(M);
  localparam int RD    = N + XD;
  localparam int NODES = M - 2;
  localparam int CW    = count_width(M);

  logic [NODES-1:0]         cfw    [RD];
  logic [CW-1:0]            cout_w [RD];
  logic [RD-2:0][CW-1:0]    cla_cin;
  logic [RD-1:0][3:0]       dig_w;
  logic [RD-1:0][3:0]       sum_w;
  logic                     top_spill;

  for (genvar j = 0; j < RD; j++) begin : g_col
    logic [M-1:0][3:0] col_ops;
    logic [NODES-1:0]  col_cin;
    logic [4:0]        col_z0;

    for (genvar r = 0; r < M; r++) begin : g_op
      if (j < N) begin : g_live
        assign col_ops[r] = operands[(r*N + j)*4 +: 4];
      end else begin : g_pad
        assign col_ops[r] = 4'd0;
      end
    end

    if (j == 0) begin : g_c0
      assign col_cin = '0;
    end else begin : g_cn
      assign col_cin = cfw[j-1];
    end

    bcd_column #(.M(M)) u_col (
      .op_dig(col_ops),
      .cin   (col_cin),
      .cfwd  (cfw[j]),
      .z0    (col_z0)
    );

    bcd_digit_fix #(.M(M)) u_fix (
      .z0   (col_z0),
      .cfwd (cfw[j]),
      .digit(dig_w[j]),
      .cout (cout_w[j])
    );

    if (j < RD - 1) begin : g_owed
      assign cla_cin[j] = cout_w[j];
    end
  end

  bcd_final_cla #(.M(M), .RD(RD)) u_cla (
    .digs(dig_w),
    .owed(cla_cin),
    .sum (sum_w)
  );

  // Anything leaving the top column would be lost; the checker watches it.
  assign top_spill = (|cfw[RD-1]) | (|cout_w[RD-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sum_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) sum_out <= sum_w;
    end
  end
endmodule

// File: rtl/bcd_multi_adder_chk.sv
module bcd_multi_adder_chk
  import bcd_madd_pkg::*;
#(
  parameter int M = 5,
  parameter int N = 4
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             in_valid,
  input logic [M*N*4-1:0]                 operands,
  input logic                             out_valid,
  input logic [(N+extra_digits(M))*4-1:0] sum_out,
  input logic                             top_spill
);
  localparam int RD = N + extra_digits(M);

  assert_valid_follow_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_reset_clear_R5: assert property (@(posedge clk)
    rst |=> (!out_valid && sum_out == '0));

  assert_hold_sum_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(sum_out));

  assert_zero_in_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && operands == '0) |=> (sum_out == '0));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !top_spill);

  for (genvar d = 0; d < RD; d++) begin : g_dig
    assert_digit_range_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (sum_out[d*4 +: 4] <= 4'd9));
  end
endmodule

bind bcd_multi_adder bcd_multi_adder_chk #(.M(M), .N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .operands (operands),
  .out_valid(out_valid),
  .sum_out  (sum_out),
  .top_spill(top_spill)
);

// File: tb/bcd_multi_adder_test.sv
module bcd_multi_adder_test;
  localparam int CLK_PERIOD = 10;
  localparam int ND   = 4;
  localparam int MAXM = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [MAXM*ND*4-1:0] ops_all = '0;
  logic [19:0] s5, s4, s8;
  logic [23:0] s16;
  logic v5, v4, v8, v16;
  int dg [MAXM][ND];
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_multi_adder #(.M(5), .N(ND)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .operands(ops_all[5*ND*4-1:0]), .out_valid(v5), .sum_out(s5));
  bcd_multi_adder #(.M(4), .N(ND)) uut_m4 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .operands(ops_all[4*ND*4-1:0]), .out_valid(v4), .sum_out(s4));
  bcd_multi_adder #(.M(8), .N(ND)) uut_m8 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .operands(ops_all[8*ND*4-1:0]), .out_valid(v8), .sum_out(s8));
  bcd_multi_adder #(.M(16), .N(ND)) uut_m16 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .operands(ops_all), .out_valid(v16), .sum_out(s16));

  function automatic longint ref_sum(input int m);
    longint t = 0;
    for (int k = 0; k < m; k++) begin
      longint v = 0;
      for (int d = ND - 1; d >= 0; d--) v = v * 10 + dg[k][d];
      t = t + v;
    end
    return t;
  endfunction

  function automatic logic [23:0] to_bcd(input longint v);
    logic [23:0] r;
    longint t = v;
    for (int i = 0; i < 6; i++) begin
      r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic all_bcd(input logic [23:0] v);
    logic ok = 1'b1;
    for (int i = 0; i < 6; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pack_ops();
    for (int k = 0; k < MAXM; k++)
      for (int d = 0; d < ND; d++)
        ops_all[(k*ND + d)*4 +: 4] = 4'(dg[k][d]);
  endtask

  task automatic fill(input int v);
    for (int k = 0; k < MAXM; k++)
      for (int d = 0; d < ND; d++) dg[k][d] = v;
  endtask

  task automatic apply_and_check(input string req);
    @(negedge clk);
    pack_ops();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "M4 sum",  {4'h0, s4}, to_bcd(ref_sum(4)));
    check(req, "M5 sum",  {4'h0, s5}, to_bcd(ref_sum(5)));
    check(req, "M8 sum",  {4'h0, s8}, to_bcd(ref_sum(8)));
    check(req, "M16 sum", s16,        to_bcd(ref_sum(16)));
    check("R4", "valid after strobe", {20'h0, v4, v5, v8, v16}, 24'hF);
    check("R3", "M16 digits in range", 24'(all_bcd(s16)), 24'd1);
    check("R3", "M8 digits in range", 24'(all_bcd({4'h0, s8})), 24'd1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R5", "valid after reset", {20'h0, v4, v5, v8, v16}, 24'h0);
    check("R5", "M5 sum after reset", {4'h0, s5}, 24'h0);
    check("R5", "M16 sum after reset", s16, 24'h0);
  endtask

  task automatic t_zero();
    fill(0);
    apply_and_check("R8");
  endtask

  task automatic t_all_nines();
    fill(9);
    apply_and_check("R2");
    check("R2", "M16 max total", s16, 24'h159984);
  endtask

  task automatic t_column();
    fill(0);
    for (int k = 0; k < MAXM; k++) dg[k][0] = 9 - (k % 10);
    apply_and_check("R9");
    check("R9", "M5 units column 9+8+7+6+5", {4'h0, s5}, 24'h000035);
  endtask

  task automatic t_position();
    fill(0);
    dg[3][3] = 7;
    dg[15][0] = 1;
    apply_and_check("R7");
    check("R7", "M4 top operand top digit", {4'h0, s4}, 24'h007000);
    check("R7", "M16 last operand low digit", s16, 24'h007001);
  endtask

  task automatic t_random();
    for (int n = 0; n < 20; n++) begin
      for (int k = 0; k < MAXM; k++)
        for (int d = 0; d < ND; d++) dg[k][d] = int'($urandom % 10);
      apply_and_check("R1");
    end
  endtask

  task automatic t_hold();
    logic [23:0] keep5, keep16;
    for (int k = 0; k < MAXM; k++)
      for (int d = 0; d < ND; d++) dg[k][d] = (k + d) % 10;
    apply_and_check("R1");
    keep5  = to_bcd(ref_sum(5));
    keep16 = to_bcd(ref_sum(16));
    fill(9);
    pack_ops();
    repeat (3) @(negedge clk);
    check("R6", "M5 held while idle", {4'h0, s5}, keep5);
    check("R6", "M16 held while idle", s16, keep16);
    check("R4", "valid low while idle", {20'h0, v4, v5, v8, v16}, 24'h0);
  endtask

  task automatic t_reset_mid();
    fill(3);
    apply_and_check("R1");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R5", "M8 sum cleared", {4'h0, s8}, 24'h0);
    check("R5", "M16 sum cleared", s16, 24'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    fails++;
    $display("FAIL R1 watchdog: actual still running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    fill(0);
    t_reset();
    t_zero();
    t_all_nines();
    t_column();
    t_position();
    t_random();
    t_hold();
    t_reset_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule